// File: doc/BRIEF.md
# Single-Phase PCI Target Responder

This block is the bus-facing half of a 32-bit, 33 MHz target-only PCI device. It takes one data phase per transaction. It recognises three kinds of access: type-0 configuration cycles aimed at function 0 while IDSEL is high, I/O cycles inside one I/O window, and memory cycles inside one memory window. Both windows are fixed by parameters. It drives DEVSEL#, TRDY# and STOP#, drives read data and PAR, and checks parity on the address phase. A byte-wide request port reaches a local function that holds the actual registers.

Every transfer finishes as a disconnect with data, so a master can never stretch an access into a burst. Each access is reduced to a single byte lane before it reaches the backend. For I/O, the lane comes from the low address bits. For memory, it comes from a lane-select input, so that big-endian hosts can move the byte. For configuration, it is the lowest enabled byte. An access whose byte enable does not cover that lane still completes on the bus, but it never reaches the backend. While an external configuration load is in progress, the busy input makes every claimed access end in Retry.

Top module: `pci_one_phase_target`

## Requirements
- R1: For a claimed cycle, DEVSEL# goes low after the first rising edge that follows the edge where FRAME# is first sampled low. The master therefore sees it at the second edge after the address edge, and never at the first.
- R2: When the master sets IRDY# low on a claimed, non-busy cycle, TRDY# and STOP# go low together for exactly one clock. After the next edge, DEVSEL#, TRDY# and STOP# are all high again. Out of reset all three are high, and AD and PAR are not driven.
- R3: While `busy_load` is high at the data edge, a claimed cycle is answered with STOP# low and TRDY# high (Retry), and no backend request is issued.
- R4: For I/O cycles, the active lane is the one given by AD[1:0] of the address. The backend request is issued only when the byte enable of that lane is low (asserted). Otherwise the cycle completes normally, with no request and read data of zero.
- R5: For memory cycles, the active lane is `lane_sel`: 0 selects AD[7:0], 1 selects AD[15:8], 2 selects AD[23:16] and 3 selects AD[31:24]. A byte enable that does not cover that lane completes with no effect. The backend address is AD[9:2].
- R6: The address phase is checked for even parity over AD[31:0], C/BE#[3:0] and PAR, using the PAR value in the following clock. On a mismatch, SERR# goes low for one clock, in the clock after the address edge, and only when `cmd_serr_en` and `cmd_perr_resp` are both high. A claimed cycle with a parity error still completes.
- R7: Commands 0010/0011 are I/O, and the address is claimed when AD[31:IO_LOG] equals the I/O base. Commands 0110/0111/1100/1110/1111 are memory, and the address is claimed when AD[31:MEM_LOG] equals the memory base. Commands 1010/1011 are configuration, and they are claimed only with IDSEL high, AD[10:8]=0 and AD[1:0]=00. Every other cycle, including special, dual-address and reserved commands, leaves DEVSEL# high.
- R8: A new address phase is accepted on the edge right after a completed data phase, with no idle clock between the frames.
- R9: PAR is driven during the clock after a read data phase, as even parity over the read data and that phase's C/BE#[3:0].
- R10: The backend sees `bk_req` for one clock during the data phase of an effective access. With it come `bk_kind` (1 = config, 2 = I/O, 3 = memory), `bk_write` (command bit 0), `bk_addr` and `bk_wdata`. `bk_addr` is the in-window I/O offset, or AD[9:2] for memory, or {AD[7:2], lane} for configuration, where the configuration lane is the lowest asserted byte enable. `bk_wdata` is the write byte taken from the active lane. Read data is the backend byte repeated on all four lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low reset |
| frame_n | input | 1 | FRAME# from the master |
| irdy_n | input | 1 | IRDY# from the master |
| idsel | input | 1 | Configuration device select |
| cbe_n | input | 4 | Command / byte enables |
| ad_in | input | 32 | AD bus as received |
| par_in | input | 1 | PAR as received |
| busy_load | input | 1 | Configuration load in progress: retry all |
| cmd_serr_en | input | 1 | SERR enable command bit |
| cmd_perr_resp | input | 1 | Parity response command bit |
| lane_sel | input | 2 | Active byte lane for memory cycles |
| ad_out | output | 32 | Read data |
| ad_oe | output | 1 | Drive enable for AD |
| par_out | output | 1 | Read data parity |
| par_oe | output | 1 | Drive enable for PAR |
| devsel_n | output | 1 | DEVSEL# |
| trdy_n | output | 1 | TRDY# |
| stop_n | output | 1 | STOP# |
| serr_n | output | 1 | SERR# |
| bk_req | output | 1 | Backend access strobe |
| bk_write | output | 1 | Backend write when high |
| bk_kind | output | 2 | Access kind: 1 config, 2 I/O, 3 memory |
| bk_addr | output | BK_AW | Backend byte address |
| bk_wdata | output | 8 | Backend write byte |
| bk_rdata | input | 8 | Backend read byte |

## Verification
The bench checks that DEVSEL# is still high one clock after the address edge. A fast-decode design would fail that check, and a slower one would fail the next. It runs mismatched byte lanes for I/O and memory, and lane 3 under a moved lane select. A design that ignored the lane would emit a backend request the scoreboard does not expect, or would return non-zero read data. Configuration cycles with IDSEL low or a non-zero function, an address just outside the I/O window, and a special cycle must all leave DEVSEL# high. The bench also sends busy retries, which must produce no TRDY# and no request, and bad address parity with the enables both on and then off. Most claimed cycles run back to back, so a responder that needed an idle clock would miss the following frame.

// File: rtl/pci1_pkg.sv
`timescale 1ns/1ps
package pci1_pkg;
   localparam logic [1:0] KIND_NONE = 2'd0;
   localparam logic [1:0] KIND_CFG  = 2'd1;
   localparam logic [1:0] KIND_IO   = 2'd2;
   localparam logic [1:0] KIND_MEM  = 2'd3;

   localparam int LANES = 4;

   typedef enum logic [2:0] {
      ST_IDLE, ST_DEC, ST_ACT, ST_XFER, ST_RETRY, ST_IGN
   } tgt_state_e;

   function automatic logic even_par(input logic [31:0] d, input logic [3:0] c);
      return ^{d, c};
   endfunction
endpackage

// File: rtl/pci1_addr_decode.sv
`timescale 1ns/1ps
module pci1_addr_decode #(
   parameter logic [31:0] IO_BASE  = 32'h0000_0300,
   parameter int          IO_LOG   = 3,
   parameter logic [31:0] MEM_BASE = 32'h8000_0000,
   parameter int          MEM_LOG  = 12,
   parameter int          BK_AW    = 8
) (
   input  logic [31:0] ad,
   input  logic [3:0]  cmd,
   input  logic        idsel,
   output logic [1:0]  kind,
   output logic        is_write
);
   import pci1_pkg::*;

   if (IO_LOG < 2 || IO_LOG > BK_AW) begin : g_bad_io
      $error("IO_LOG must lie between 2 and BK_AW");
   end
   if (MEM_LOG < BK_AW + 2 || MEM_LOG > 31) begin : g_bad_mem
      $error("MEM_LOG must lie between BK_AW+2 and 31");
   end
   if (BK_AW < 8) begin : g_bad_aw
      $error("BK_AW must be at least 8");
   end

   logic io_cmd, mem_cmd, cfg_cmd;
   logic io_in, mem_in, cfg_ok;

   always_comb begin
      io_cmd  = (cmd == 4'b0010) || (cmd == 4'b0011);
      mem_cmd = (cmd == 4'b0110) || (cmd == 4'b0111) || (cmd == 4'b1100)
             || (cmd == 4'b1110) || (cmd == 4'b1111);
      cfg_cmd = (cmd == 4'b1010) || (cmd == 4'b1011);
      io_in   = ad[31:IO_LOG]  == IO_BASE[31:IO_LOG];
      mem_in  = ad[31:MEM_LOG] == MEM_BASE[31:MEM_LOG];
      cfg_ok  = idsel && (ad[10:8] == 3'b000) && (ad[1:0] == 2'b00);
      if (io_cmd && io_in)        kind = KIND_IO;
      else if (mem_cmd && mem_in) kind = KIND_MEM;
      else if (cfg_cmd && cfg_ok) kind = KIND_CFG;
      else                        kind = KIND_NONE;
      is_write = cmd[0];
   end

   logic unused_ad;
   assign unused_ad = ^ad;
endmodule

// File: rtl/pci1_lane_qual.sv
`timescale 1ns/1ps
module pci1_lane_qual #(
   parameter int IO_LOG = 3,
   parameter int BK_AW  = 8
) (
   input  logic [1:0]       kind,
   input  logic [BK_AW+1:0] ad_lo,
   input  logic [3:0]       be_n,
   input  logic [1:0]       lane_sel,
   input  logic [31:0]      data,
   output logic             effect,
   output logic [BK_AW-1:0] bk_addr,
   output logic [7:0]       wbyte
);
   import pci1_pkg::*;

   logic [1:0]       lane;
   logic [1:0]       cfg_lane;
   logic [BK_AW-1:0] io_off, mem_off, cfg_off;

   always_comb begin
      if (!be_n[0])      cfg_lane = 2'd0;
      else if (!be_n[1]) cfg_lane = 2'd1;
      else if (!be_n[2]) cfg_lane = 2'd2;
      else               cfg_lane = 2'd3;

      io_off = '0;
      io_off[IO_LOG-1:0] = ad_lo[IO_LOG-1:0];
      mem_off = ad_lo[BK_AW+1:2];
      cfg_off = '0;
      cfg_off[7:0] = {ad_lo[7:2], cfg_lane};

      case (kind)
         KIND_IO: begin
            lane    = ad_lo[1:0];
            effect  = !be_n[ad_lo[1:0]];
            bk_addr = io_off;
         end
         KIND_MEM: begin
            lane    = lane_sel;
            effect  = !be_n[lane_sel];
            bk_addr = mem_off;
         end
         KIND_CFG: begin
            lane    = cfg_lane;
            effect  = (be_n != 4'hF);
            bk_addr = cfg_off;
         end
         default: begin
            lane    = 2'd0;
            effect  = 1'b0;
            bk_addr = '0;
         end
      endcase
      wbyte = data[8*lane +: 8];
   end
endmodule

// File: rtl/pci1_addr_parity.sv
`timescale 1ns/1ps
module pci1_addr_parity (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        addr_phase,
   input  logic [31:0] ad,
   input  logic [3:0]  cbe_n,
   input  logic        par_in,
   input  logic        serr_en,
   input  logic        perr_resp,
   output logic        serr_n
);
   import pci1_pkg::*;

   logic pending, exp_par;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b0;
         exp_par <= 1'b0;
         serr_n  <= 1'b1;
      end else begin
         pending <= addr_phase;
         if (addr_phase) exp_par <= even_par(ad, cbe_n);
         serr_n <= !(pending && (par_in != exp_par) && serr_en && perr_resp);
      end
   end

   // R6: SERR# is a single-clock pulse
   p_serr_one_clk_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !serr_n |=> serr_n);
   // R6: SERR# only with both command bits set
   p_serr_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !serr_n |-> $past(serr_en && perr_resp));
endmodule

// File: rtl/pci_one_phase_target.sv
`timescale 1ns/1ps
module pci_one_phase_target #(
   parameter logic [31:0] IO_BASE  = 32'h0000_0300,
   parameter int          IO_LOG   = 3,
   parameter logic [31:0] MEM_BASE = 32'h8000_0000,
   parameter int          MEM_LOG  = 12,
   parameter int          BK_AW    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_n,
   input  logic             irdy_n,
   input  logic             idsel,
   input  logic [3:0]       cbe_n,
   input  logic [31:0]      ad_in,
   input  logic             par_in,
   input  logic             busy_load,
   input  logic             cmd_serr_en,
   input  logic             cmd_perr_resp,
   input  logic [1:0]       lane_sel,
   output logic [31:0]      ad_out,
   output logic             ad_oe,
   output logic             par_out,
   output logic             par_oe,
   output logic             devsel_n,
   output logic             trdy_n,
   output logic             stop_n,
   output logic             serr_n,
   output logic             bk_req,
   output logic             bk_write,
   output logic [1:0]       bk_kind,
   output logic [BK_AW-1:0] bk_addr,
   output logic [7:0]       bk_wdata,
   input  logic [7:0]       bk_rdata
);
   import pci1_pkg::*;

   localparam int ALO = BK_AW + 2;

   tgt_state_e     st;
   logic [1:0]     dec_kind, kind_q;
   logic           dec_wr, wr_q, effect;
   logic [ALO-1:0] ad_q;
   logic [3:0]     be_q;
   logic           addr_phase;

   assign addr_phase = (st == ST_IDLE) && !frame_n;

   pci1_addr_decode #(.IO_BASE(IO_BASE), .IO_LOG(IO_LOG), .MEM_BASE(MEM_BASE),
                      .MEM_LOG(MEM_LOG), .BK_AW(BK_AW)) u_dec (
      .ad(ad_in), .cmd(cbe_n), .idsel(idsel), .kind(dec_kind), .is_write(dec_wr));

   pci1_lane_qual #(.IO_LOG(IO_LOG), .BK_AW(BK_AW)) u_lane (
      .kind(kind_q), .ad_lo(ad_q), .be_n(cbe_n), .lane_sel(lane_sel), .data(ad_in),
      .effect(effect), .bk_addr(bk_addr), .wbyte(bk_wdata));

   pci1_addr_parity u_par (
      .clk(clk), .rst_n(rst_n), .addr_phase(addr_phase), .ad(ad_in), .cbe_n(cbe_n),
      .par_in(par_in), .serr_en(cmd_serr_en), .perr_resp(cmd_perr_resp), .serr_n(serr_n));

   assign bk_req   = (st == ST_ACT) && !irdy_n && !busy_load && effect;
   assign bk_write = wr_q;
   assign bk_kind  = kind_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         devsel_n <= 1'b1;
         trdy_n   <= 1'b1;
         stop_n   <= 1'b1;
         ad_oe    <= 1'b0;
         ad_out   <= '0;
         par_out  <= 1'b0;
         par_oe   <= 1'b0;
         ad_q     <= '0;
         be_q     <= '0;
         kind_q   <= KIND_NONE;
         wr_q     <= 1'b0;
      end else begin
         par_oe <= 1'b0;
         case (st)
            ST_IDLE: if (!frame_n) begin
               ad_q   <= ad_in[ALO-1:0];
               kind_q <= dec_kind;
               wr_q   <= dec_wr;
               st     <= ST_DEC;
            end
            ST_DEC: if (kind_q != KIND_NONE) begin
               devsel_n <= 1'b0;
               st       <= ST_ACT;
            end else begin
               st <= ST_IGN;
            end
            ST_ACT: if (!irdy_n) begin
               be_q   <= cbe_n;
               stop_n <= 1'b0;
               if (busy_load) begin
                  st <= ST_RETRY;
               end else begin
                  trdy_n <= 1'b0;
                  st     <= ST_XFER;
                  if (!wr_q) begin
                     ad_out <= effect ? {LANES{bk_rdata}} : '0;
                     ad_oe  <= 1'b1;
                  end
               end
            end
            ST_XFER: begin
               devsel_n <= 1'b1;
               trdy_n   <= 1'b1;
               stop_n   <= 1'b1;
               ad_oe    <= 1'b0;
               if (!wr_q) begin
                  par_out <= even_par(ad_out, be_q);
                  par_oe  <= 1'b1;
               end
               st <= ST_IDLE;
            end
            ST_RETRY: begin
               devsel_n <= 1'b1;
               stop_n   <= 1'b1;
               st       <= ST_IDLE;
            end
            ST_IGN: if (frame_n && irdy_n) st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R1: medium-speed claim, two edges after the address edge
   p_devsel_medium_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(devsel_n) |-> $past(!frame_n, 2));
   // R2: TRDY# always comes with STOP# and DEVSEL#
   p_disconnect_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !trdy_n |-> (!stop_n && !devsel_n));
   // R2: single data phase
   p_trdy_one_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !trdy_n |=> (trdy_n && stop_n && devsel_n));
   // R3: STOP# without TRDY# only as a busy retry
   p_retry_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(stop_n) && trdy_n |-> $past(busy_load));
   // R9: PAR follows a driven read phase
   p_par_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
      par_oe |-> $past(!trdy_n && ad_oe));
endmodule

// File: tb/pci_one_phase_target_tb_top.sv
`timescale 1ns/1ps
module pci_one_phase_target_tb_top;
   localparam int CLK_PERIOD = 30;

   typedef struct packed {
      logic [1:0] kind;
      logic       wr;
      logic [7:0] addr;
      logic [7:0] wbyte;
   } bk_item_t;

   logic        clk = 0, rst_n = 0;
   logic        frame_n = 1, irdy_n = 1, idsel = 0, par_in = 0, busy_load = 0;
   logic [3:0]  cbe_n = 0;
   logic [31:0] ad_in = 0;
   logic        serr_en = 1, perr_resp = 1;
   logic [1:0]  lane_sel = 0;
   logic [31:0] ad_out;
   logic        ad_oe, par_out, par_oe, devsel_n, trdy_n, stop_n, serr_n;
   logic        bk_req, bk_write;
   logic [1:0]  bk_kind;
   logic [7:0]  bk_addr, bk_wdata, bk_rdata;

   int checks = 0, errors = 0;
   bit done = 0;
   bk_item_t exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;
   assign bk_rdata = bk_addr ^ 8'hA5;

   pci_one_phase_target dut_i (
      .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel),
      .cbe_n(cbe_n), .ad_in(ad_in), .par_in(par_in), .busy_load(busy_load),
      .cmd_serr_en(serr_en), .cmd_perr_resp(perr_resp), .lane_sel(lane_sel),
      .ad_out(ad_out), .ad_oe(ad_oe), .par_out(par_out), .par_oe(par_oe),
      .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n), .serr_n(serr_n),
      .bk_req(bk_req), .bk_write(bk_write), .bk_kind(bk_kind), .bk_addr(bk_addr),
      .bk_wdata(bk_wdata), .bk_rdata(bk_rdata));

   task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", what, act, exp);
      end
   endtask

   // scoreboard monitor: R10
   always @(negedge clk) begin
      if (rst_n && bk_req) begin
         if (exp_q.size() == 0) begin
            chk("R10 unexpected backend request", {bk_kind, bk_write, bk_addr}, 32'h0);
         end else begin
            bk_item_t e;
            e = exp_q.pop_front();
            chk("R10 backend request", {bk_kind, bk_write, bk_addr, bk_write ? bk_wdata : 8'h00},
                {13'h0, e});
         end
      end
   end

   function automatic logic [1:0] kind_of(input logic [3:0] c);
      case (c)
         4'b0010, 4'b0011: return 2'd2;
         4'b0110, 4'b0111, 4'b1100, 4'b1110, 4'b1111: return 2'd3;
         4'b1010, 4'b1011: return 2'd1;
         default: return 2'd0;
      endcase
   endfunction

   // called at a falling edge; returns at the falling edge after the data phase
   task automatic xact(input logic [3:0] cmd, input logic [31:0] addr, input logic [3:0] be,
                       input logic [31:0] wd, input bit sel, input bit bad_par,
                       input bit hit, input bit busy, input string tag);
      logic [1:0]  k, lane;
      logic [7:0]  ea;
      logic [31:0] rd;
      bit          wr, eff;
      bk_item_t    it;
      k  = kind_of(cmd);
      wr = cmd[0];
      if (k == 2'd2)      lane = addr[1:0];
      else if (k == 2'd3) lane = lane_sel;
      else                lane = !be[0] ? 2'd0 : !be[1] ? 2'd1 : !be[2] ? 2'd2 : 2'd3;
      eff = (k == 2'd1) ? (be != 4'hF) : !be[lane];
      ea  = (k == 2'd2) ? {5'b0, addr[2:0]} : (k == 2'd3) ? addr[9:2] : {addr[7:2], lane};
      rd  = eff ? {4{ea ^ 8'hA5}} : 32'h0;

      frame_n = 0; ad_in = addr; cbe_n = cmd; idsel = sel; busy_load = busy;
      @(negedge clk);
      frame_n = 1; irdy_n = 0; cbe_n = be; ad_in = wr ? wd : 32'h0;
      par_in = (^{addr, cmd}) ^ bad_par;
      chk({tag, " R1 no claim one clock after address"}, devsel_n, 1'b1);
      if (hit && eff && !busy) begin
         it.kind = k; it.wr = wr; it.addr = ea; it.wbyte = wr ? wd[8*lane +: 8] : 8'h00;
         exp_q.push_back(it);
      end
      @(negedge clk);
      chk({tag, hit ? " R1 DEVSEL# asserted" : " R7 cycle not claimed"}, devsel_n, !hit);
      chk({tag, " R2 TRDY# not yet"}, trdy_n, 1'b1);
      chk({tag, " R6 SERR# after address"}, serr_n, !(bad_par && serr_en && perr_resp));
      @(negedge clk);
      chk({tag, " R6 SERR# one clock"}, serr_n, 1'b1);
      if (!hit) begin
         chk({tag, " R7 no response"}, {devsel_n, trdy_n, stop_n}, 3'b111);
      end else if (busy) begin
         chk({tag, " R3 retry STOP# without TRDY#"}, {devsel_n, trdy_n, stop_n}, 3'b010);
      end else begin
         chk({tag, " R2 TRDY# with STOP#"}, {devsel_n, trdy_n, stop_n}, 3'b000);
         if (!wr) begin
            chk({tag, " R9 AD driven"}, ad_oe, 1'b1);
            chk({tag, eff ? " R10 read data lanes" : " R4 no-effect read data"}, ad_out, rd);
         end
      end
      @(negedge clk);
      chk({tag, " R2 released after one phase"}, {devsel_n, trdy_n, stop_n, ad_oe}, 4'b1110);
      if (hit && !busy && !wr) begin
         chk({tag, " R9 PAR driven"}, par_oe, 1'b1);
         chk({tag, " R9 PAR value"}, par_out, ^{rd, be});
      end
      irdy_n = 1; cbe_n = 0; ad_in = 0; idsel = 0; busy_load = 0; par_in = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R2 reset outputs", {devsel_n, trdy_n, stop_n, serr_n, ad_oe, par_oe, bk_req},
          7'b1111000);

      // I/O lanes: R4
      xact(4'b0011, 32'h305, 4'b1101, 32'hAABBCCDD, 0, 0, 1, 0, "R4 io write lane1");
      xact(4'b0011, 32'h306, 4'b1101, 32'h11111111, 0, 0, 1, 0, "R4 io write lane mismatch");
      xact(4'b0010, 32'h304, 4'b1110, 32'h0, 0, 0, 1, 0, "R9 io read");
      xact(4'b0010, 32'h307, 4'b1110, 32'h0, 0, 0, 1, 0, "R4 io read mismatch");
      // memory lanes: R5
      xact(4'b0111, 32'h8000_0010, 4'b1110, 32'h11223344, 0, 0, 1, 0, "R5 mem write lane0");
      lane_sel = 2'd3;
      xact(4'b0111, 32'h8000_0020, 4'b0111, 32'h11223344, 0, 0, 1, 0, "R5 mem write lane3");
      xact(4'b0111, 32'h8000_0024, 4'b1110, 32'h55667788, 0, 0, 1, 0, "R5 mem lane mismatch");
      lane_sel = 2'd2;
      xact(4'b1110, 32'h8000_03FC, 4'b1011, 32'h0, 0, 0, 1, 0, "R5 mem read line lane2");
      // configuration: R10
      xact(4'b1010, 32'h0000_0044, 4'b1011, 32'h0, 1, 0, 1, 0, "R10 cfg read");
      xact(4'b1011, 32'h0000_0008, 4'b0000, 32'h12345678, 1, 0, 1, 0, "R10 cfg write");
      // ignored cycles: R7
      xact(4'b1010, 32'h0000_0044, 4'b0000, 32'h0, 0, 0, 0, 0, "R7 cfg without IDSEL");
      idle(1);
      xact(4'b1010, 32'h0000_0144, 4'b0000, 32'h0, 1, 0, 0, 0, "R7 cfg function1");
      idle(1);
      xact(4'b0011, 32'h0000_0308, 4'b1110, 32'h0, 0, 0, 0, 0, "R7 io outside window");
      idle(1);
      xact(4'b0001, 32'h0000_0305, 4'b0000, 32'h0, 0, 0, 0, 0, "R7 special cycle");
      idle(1);
      xact(4'b0110, 32'h9000_0000, 4'b0000, 32'h0, 0, 0, 0, 0, "R7 mem outside window");
      idle(1);
      // busy retry: R3
      xact(4'b0011, 32'h305, 4'b1101, 32'hAABBCCDD, 0, 0, 1, 1, "R3 busy write");
      xact(4'b0010, 32'h304, 4'b1110, 32'h0, 0, 0, 1, 1, "R3 busy read");
      // address parity: R6
      xact(4'b0011, 32'h301, 4'b1101, 32'hCAFE0000, 0, 1, 1, 0, "R6 bad parity completes");
      perr_resp = 0;
      xact(4'b0011, 32'h301, 4'b1101, 32'hCAFE0000, 0, 1, 1, 0, "R6 parity response off");
      perr_resp = 1;
      serr_en = 0;
      xact(4'b0011, 32'h301, 4'b1101, 32'hCAFE0000, 0, 1, 1, 0, "R6 SERR enable off");
      serr_en = 1;
      // back to back frames: R8
      xact(4'b0011, 32'h302, 4'b1011, 32'h00EE0000, 0, 0, 1, 0, "R8 first frame");
      xact(4'b0010, 32'h302, 4'b1011, 32'h0, 0, 0, 1, 0, "R8 second frame");
      idle(2);
      chk("R10 all expected requests seen", exp_q.size(), 0);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog R2 bench hung actual %0d expected %0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule